// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display output channel. It runs a horizontal counter and a vertical counter on a pixel-clock enable. From them it decodes the horizontal and vertical sync pulses, the data-enable window, a pulse at the start of each frame, an interlace field flag and an early pre-start pulse. The pre-start pulse comes a programmable number of lines before active video, so that downstream fetch logic has time to prepare.

Timing is described by a set of configuration inputs: active size, totals, sync widths, back-porch values, sync polarity, interlace enable and a channel select. The back-porch values are measured from the start of sync and so include the sync width. When the secondary channel is selected in progressive mode, the vertical total is given in half-lines. The block also computes an early start delay from the vertical blanking length.

Configuration is copied into shadow registers. While the channel is off, the copy follows the inputs freely. While the channel runs, the copy is taken only at the end of a frame, so a write in the middle of a frame never tears the picture.

Top module: `vtg_top`

## Requirements
- R1: The horizontal position `pos_x` counts 0 to `h_total`-1 and advances by one on each pixel tick. The raw horizontal sync is active while `pos_x` < `h_sync`.
- R2: A field has `v_total` lines for the primary channel in progressive mode. It has `v_total`/2 lines when the secondary channel is in progressive mode (half-line count) or when interlace is on. `pos_y` steps at each line wrap, and the raw vertical sync is active while `pos_y` < `v_sync`.
- R3: `de` is high when `h_bp` <= `pos_x` < `h_bp`+`h_active` and `v_bp` <= `pos_y` < `v_bp`+`v_act_f`. Here `v_act_f` is `v_active`/2 when interlaced and `v_active` otherwise.
- R4: `cfg_hs_low`=1 makes `hsync` active-low, and `cfg_vs_low`=1 makes `vsync` active-low. Each bit affects only its own output.
- R5: `start_delay` is the vertical blanking line count, computed as frame lines minus `v_active`, where frame lines are `v_total`/2 for secondary progressive and `v_total` otherwise. It is halved when interlaced, reduced by 2 (floored at 0) for the secondary channel, and capped at 30.
- R6: `pre_start` pulses on the tick at `pos_x`=0 of line `v_bp`-`start_delay`. When that value would be negative, the line is `v_bp`+lines per field-`start_delay`.
- R7: While `enable` is low, `out_en` is 0, `hsync`, `vsync`, `de`, `frame_start` and `pre_start` are 0, and the counters are held at 0. The first tick after `enable` rises shows position (0,0).
- R8: While the channel is running, configuration changes take effect only at the end of a frame (after field 1 when interlaced). While it is off, they take effect on the next clock.
- R9: `frame_start` is high on the tick at (0,0) of field 0. `field` toggles at each field end when interlaced and stays 0 otherwise.
- R10: The counters hold their values on cycles where `pix_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel tick enable |
| enable | input | 1 | Channel enable |
| cfg_h_active | input | 12 | Active width in pixels |
| cfg_h_total | input | 12 | Pixels per line |
| cfg_h_bp | input | 12 | Sync plus back porch, in pixels |
| cfg_h_sync | input | 12 | Horizontal sync width |
| cfg_v_active | input | 12 | Active height in lines (frame) |
| cfg_v_total | input | 12 | Vertical total (half-lines for secondary progressive) |
| cfg_v_bp | input | 12 | Sync plus back porch, in lines |
| cfg_v_sync | input | 12 | Vertical sync width in lines |
| cfg_hs_low | input | 1 | Horizontal sync active-low |
| cfg_vs_low | input | 1 | Vertical sync active-low |
| cfg_interlace | input | 1 | Interlaced scan |
| cfg_chan_sec | input | 1 | Secondary channel select |
| out_en | output | 1 | Output drive enable (0 = tristate) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pos_x | output | 12 | Horizontal position |
| pos_y | output | 12 | Vertical position (lines in field) |
| frame_start | output | 1 | Start-of-frame pulse |
| field | output | 1 | Current interlace field |
| pre_start | output | 1 | Early start pulse |
| start_delay | output | 5 | Computed early start delay in lines |

## Verification
The checker watches, on every cycle, the local invariants. The outputs stay quiet and the counters stay at zero while the channel is off. The horizontal position stays in range, steps by one per tick and holds when there is no tick. The frame pulse is seen only at the origin of field 0, data enable never appears left of the back porch, and the delay never goes above its cap. Some behaviour needs a whole raster to show: the exact placement of each sync and data window, the half-line and interlaced line counts, the pre-start line, the deferred pickup of a mid-frame polarity change and the delay arithmetic corners. Only the bench scenarios, which compare against a reference raster walked in step, can show these.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int CW      = 12;
    localparam int DLY_W   = 5;
    localparam int DLY_MAX = 30;
    localparam int SEC_ADJ = 2;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t h_act;
        cnt_t h_tot;
        cnt_t h_bp;
        cnt_t h_sw;
        cnt_t v_act;
        cnt_t v_tot;
        cnt_t v_bp;
        cnt_t v_sw;
        logic hs_low;
        logic vs_low;
        logic ilace;
        logic chan_sec;
    } vcfg_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  vcfg_t cfg_in,
    output vcfg_t cfg_q
);
    vcfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/vtg_derive.sv
module vtg_derive
    import vtg_pkg::*;
(
    input  vcfg_t            cfg,
    output cnt_t             v_lines,
    output cnt_t             v_act_f,
    output logic [DLY_W-1:0] delay,
    output cnt_t             pre_line
);
    localparam cnt_t ADJ_C = cnt_t'(SEC_ADJ);
    localparam cnt_t MAX_C = cnt_t'(DLY_MAX);

    cnt_t frame_lines;
    cnt_t blank;
    cnt_t field_blank;
    cnt_t adj;
    cnt_t dly_w;

    always_comb begin
        frame_lines = (cfg.chan_sec && !cfg.ilace) ? (cfg.v_tot >> 1) : cfg.v_tot;
        v_lines     = (cfg.chan_sec || cfg.ilace) ? (cfg.v_tot >> 1) : cfg.v_tot;
        v_act_f     = cfg.ilace ? (cfg.v_act >> 1) : cfg.v_act;
        blank       = (frame_lines > cfg.v_act) ? (frame_lines - cfg.v_act) : '0;
        field_blank = cfg.ilace ? (blank >> 1) : blank;
        if (cfg.chan_sec) begin
            adj = (field_blank > ADJ_C) ? (field_blank - ADJ_C) : '0;
        end else begin
            adj = field_blank;
        end
        dly_w = (adj > MAX_C) ? MAX_C : adj;
        delay = dly_w[DLY_W-1:0];
        if (cfg.v_bp >= dly_w) begin
            pre_line = cfg.v_bp - dly_w;
        end else begin
            pre_line = cfg.v_bp + v_lines - dly_w;
        end
    end
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pix_en,
    input  cnt_t h_tot,
    input  cnt_t v_lines,
    input  logic ilace,
    output cnt_t h_q,
    output cnt_t v_q,
    output logic field_q,
    output logic run_q,
    output logic frame_end
);
    typedef struct packed {
        logic run;
        cnt_t h;
        cnt_t v;
        logic field;
    } scan_t;

    scan_t st_q, st_d;
    logic  h_last, v_last;

    always_comb begin
        h_last    = ({1'b0, st_q.h} + 1'b1) >= {1'b0, h_tot};
        v_last    = ({1'b0, st_q.v} + 1'b1) >= {1'b0, v_lines};
        frame_end = st_q.run && pix_en && h_last && v_last && (!ilace || st_q.field);
        st_d      = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            st_d.run = 1'b1;
            if (st_q.run && pix_en) begin
                if (h_last) begin
                    st_d.h = '0;
                    if (v_last) begin
                        st_d.v     = '0;
                        st_d.field = ilace ? ~st_q.field : 1'b0;
                    end else begin
                        st_d.v = st_q.v + 1'b1;
                    end
                end else begin
                    st_d.h = st_q.h + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_q     = st_q.h;
    assign v_q     = st_q.v;
    assign field_q = st_q.field;
    assign run_q   = st_q.run;
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             enable,
    input  logic [CW-1:0]    cfg_h_active,
    input  logic [CW-1:0]    cfg_h_total,
    input  logic [CW-1:0]    cfg_h_bp,
    input  logic [CW-1:0]    cfg_h_sync,
    input  logic [CW-1:0]    cfg_v_active,
    input  logic [CW-1:0]    cfg_v_total,
    input  logic [CW-1:0]    cfg_v_bp,
    input  logic [CW-1:0]    cfg_v_sync,
    input  logic             cfg_hs_low,
    input  logic             cfg_vs_low,
    input  logic             cfg_interlace,
    input  logic             cfg_chan_sec,
    output logic             out_en,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CW-1:0]    pos_x,
    output logic [CW-1:0]    pos_y,
    output logic             frame_start,
    output logic             field,
    output logic             pre_start,
    output logic [DLY_W-1:0] start_delay
);
    vcfg_t cfg_in, cfg_q;
    cnt_t  v_lines, v_act_f, pre_line, h_q, v_q;
    logic  field_q, run_q, frame_end;
    logic  hs_raw, vs_raw, h_win, v_win;
    logic [CW:0] h_end, v_end;

    always_comb begin
        cfg_in.h_act    = cfg_h_active;
        cfg_in.h_tot    = cfg_h_total;
        cfg_in.h_bp     = cfg_h_bp;
        cfg_in.h_sw     = cfg_h_sync;
        cfg_in.v_act    = cfg_v_active;
        cfg_in.v_tot    = cfg_v_total;
        cfg_in.v_bp     = cfg_v_bp;
        cfg_in.v_sw     = cfg_v_sync;
        cfg_in.hs_low   = cfg_hs_low;
        cfg_in.vs_low   = cfg_vs_low;
        cfg_in.ilace    = cfg_interlace;
        cfg_in.chan_sec = cfg_chan_sec;
    end

    vtg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!run_q || frame_end),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    vtg_derive u_derive (
        .cfg      (cfg_q),
        .v_lines  (v_lines),
        .v_act_f  (v_act_f),
        .delay    (start_delay),
        .pre_line (pre_line)
    );

    vtg_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pix_en    (pix_en),
        .h_tot     (cfg_q.h_tot),
        .v_lines   (v_lines),
        .ilace     (cfg_q.ilace),
        .h_q       (h_q),
        .v_q       (v_q),
        .field_q   (field_q),
        .run_q     (run_q),
        .frame_end (frame_end)
    );

    always_comb begin
        h_end       = {1'b0, cfg_q.h_bp} + {1'b0, cfg_q.h_act};
        v_end       = {1'b0, cfg_q.v_bp} + {1'b0, v_act_f};
        hs_raw      = h_q < cfg_q.h_sw;
        vs_raw      = v_q < cfg_q.v_sw;
        h_win       = (h_q >= cfg_q.h_bp) && ({1'b0, h_q} < h_end);
        v_win       = (v_q >= cfg_q.v_bp) && ({1'b0, v_q} < v_end);
        out_en      = run_q;
        hsync       = run_q && (hs_raw ^ cfg_q.hs_low);
        vsync       = run_q && (vs_raw ^ cfg_q.vs_low);
        de          = run_q && h_win && v_win;
        frame_start = run_q && pix_en && (h_q == '0) && (v_q == '0) && !field_q;
        pre_start   = run_q && pix_en && (h_q == '0) && (v_q == pre_line);
        pos_x       = h_q;
        pos_y       = v_q;
        field       = field_q;
    end
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
    import vtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             pix_en,
    input logic             out_en,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic             frame_start,
    input logic             pre_start,
    input logic             field,
    input logic [CW-1:0]    pos_x,
    input logic [CW-1:0]    pos_y,
    input logic [DLY_W-1:0] start_delay,
    input logic [CW-1:0]    h_tot,
    input logic [CW-1:0]    h_bp
);
    // R7
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!hsync && !vsync && !de && !frame_start && !pre_start));

    // R7
    origin_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pos_x == '0 && pos_y == '0));

    // R10
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && enable && !pix_en) |=> ($stable(pos_x) && $stable(pos_y)));

    // R1
    x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && h_tot != '0) |-> (pos_x < h_tot));

    // R1
    x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && enable && pix_en && (({1'b0, pos_x} + 1'b1) < {1'b0, h_tot}))
        |=> (pos_x == $past(pos_x) + 1'b1));

    // R9
    fs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pos_x == '0 && pos_y == '0 && !field));

    // R3
    de_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pos_x >= h_bp));

    // R5
    delay_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_delay <= DLY_W'(DLY_MAX));
endmodule

bind vtg_top vtg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .pix_en      (pix_en),
    .out_en      (out_en),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .frame_start (frame_start),
    .pre_start   (pre_start),
    .field       (field),
    .pos_x       (pos_x),
    .pos_y       (pos_y),
    .start_delay (start_delay),
    .h_tot       (cfg_q.h_tot),
    .h_bp        (cfg_q.h_bp)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {v_total, v_active, interlace, secondary, expected delay}
    localparam logic [30:0] DLY_VEC [NV] = '{
        {12'd6,   12'd3,   1'b0, 1'b0, 5'd3},
        {12'd100, 12'd50,  1'b0, 1'b0, 5'd30},
        {12'd12,  12'd3,   1'b0, 1'b1, 5'd1},
        {12'd8,   12'd3,   1'b0, 1'b1, 5'd0},
        {12'd20,  12'd10,  1'b1, 1'b0, 5'd5},
        {12'd20,  12'd10,  1'b1, 1'b1, 5'd3},
        {12'd200, 12'd100, 1'b1, 1'b1, 5'd30},
        {12'd33,  12'd3,   1'b0, 1'b0, 5'd30},
        {12'd34,  12'd3,   1'b0, 1'b0, 5'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b1;
    logic enable = 1'b0;
    logic [11:0] h_act = 12'd4, h_tot = 12'd8, h_bp = 12'd3, h_sw = 12'd2;
    logic [11:0] v_act = 12'd3, v_tot = 12'd6, v_bp = 12'd2, v_sw = 12'd1;
    logic hs_low = 1'b0, vs_low = 1'b0, ilace = 1'b0, sec = 1'b0;
    logic out_en, hsync, vsync, de, frame_start, field, pre_start;
    logic [11:0] pos_x, pos_y;
    logic [4:0] start_delay;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtg_top u0 (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .enable(enable),
        .cfg_h_active(h_act), .cfg_h_total(h_tot), .cfg_h_bp(h_bp), .cfg_h_sync(h_sw),
        .cfg_v_active(v_act), .cfg_v_total(v_tot), .cfg_v_bp(v_bp), .cfg_v_sync(v_sw),
        .cfg_hs_low(hs_low), .cfg_vs_low(vs_low), .cfg_interlace(ilace), .cfg_chan_sec(sec),
        .out_en(out_en), .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y),
        .frame_start(frame_start), .field(field), .pre_start(pre_start), .start_delay(start_delay)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk a reference raster in step with the design; switch polarity at chg_at.
    task automatic run_frames(input int ncyc, input int vacte, input int vlines,
                              input int pre_line, input int chg_at);
        int mh = 0, mv = 0, mf = 0;
        bit hl = hs_low, vl = vs_low, pend = 1'b0;
        int e_hs = 0, e_vs = 0, e_de = 0, e_x = 0, e_y = 0, e_fs = 0, e_pre = 0, e_fld = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (hsync !== (((mh < int'(h_sw)) ? 1'b1 : 1'b0) ^ hl)) e_hs++;
            if (vsync !== (((mv < int'(v_sw)) ? 1'b1 : 1'b0) ^ vl)) e_vs++;
            if (de !== ((mh >= int'(h_bp)) && (mh < int'(h_bp + h_act)) &&
                        (mv >= int'(v_bp)) && (mv < int'(v_bp) + vacte))) e_de++;
            if (int'(pos_x) != mh) e_x++;
            if (int'(pos_y) != mv) e_y++;
            if (frame_start !== (mh == 0 && mv == 0 && mf == 0)) e_fs++;
            if (pre_start !== (mh == 0 && mv == pre_line)) e_pre++;
            if (int'(field) != mf) e_fld++;
            if (c == chg_at) begin
                hs_low = ~hs_low;
                vs_low = ~vs_low;
                pend = 1'b1;
            end
            mh++;
            if (mh == int'(h_tot)) begin
                mh = 0;
                mv++;
                if (mv == vlines) begin
                    mv = 0;
                    if (!ilace || mf == 1) begin
                        if (pend) begin
                            hl = hs_low;
                            vl = vs_low;
                            pend = 1'b0;
                        end
                    end
                    mf = ilace ? 1 - mf : 0;
                end
            end
        end
        chk(e_hs == 0, "R1/R4 hsync", e_hs, 0);
        chk(e_vs == 0, "R2/R4 vsync", e_vs, 0);
        chk(e_de == 0, "R3 de window", e_de, 0);
        chk(e_x == 0, "R1 pos_x", e_x, 0);
        chk(e_y == 0, "R2 pos_y", e_y, 0);
        chk(e_fs == 0, "R9 frame_start", e_fs, 0);
        chk(e_pre == 0, "R6 pre_start", e_pre, 0);
        chk(e_fld == 0, "R9 field", e_fld, 0);
    endtask

    task automatic restart;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic stop_and_check;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(out_en == 1'b0, "R7 out_en off", int'(out_en), 0);
        chk(!hsync && !vsync && !de, "R7 outputs quiet", int'({hsync, vsync, de}), 0);
        chk(pos_x == 0 && pos_y == 0, "R7 counters held", int'(pos_x), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(out_en == 1'b0 && de == 1'b0, "R7 reset", int'({out_en, de}), 0);
        chk(hsync == 1'b0 && vsync == 1'b0, "R7 reset syncs", int'({hsync, vsync}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 delay table, channel off so shadow follows inputs (R8)
        for (int i = 0; i < NV; i++) begin
            v_tot = DLY_VEC[i][30:19];
            v_act = DLY_VEC[i][18:7];
            ilace = DLY_VEC[i][6];
            sec   = DLY_VEC[i][5];
            @(negedge clk);
            chk(start_delay == DLY_VEC[i][4:0], "R5 start_delay",
                int'(start_delay), int'(DLY_VEC[i][4:0]));
        end

        // Primary progressive: delay 3, pre line 2+6-3=5; polarity flip mid frame (R4, R8)
        v_tot = 12'd6; v_act = 12'd3; ilace = 1'b0; sec = 1'b0;
        restart();
        run_frames(96, 3, 6, 5, 20);
        chk(start_delay == 5'd3, "R5 running delay", int'(start_delay), 3);

        // R10: no tick holds position
        begin
            logic [11:0] hx;
            @(negedge clk);
            pix_en = 1'b0;
            hx = pos_x;
            repeat (3) @(negedge clk);
            chk(pos_x == hx, "R10 hold x", int'(pos_x), int'(hx));
            pix_en = 1'b1;
        end
        stop_and_check();

        // Secondary progressive, half-line total 12 -> 6 lines, delay 1, pre line 1 (R2)
        hs_low = 1'b0; vs_low = 1'b0;
        v_tot = 12'd12; sec = 1'b1;
        restart();
        run_frames(96, 3, 6, 1, -1);
        chk(start_delay == 5'd1, "R5 secondary delay", int'(start_delay), 1);
        stop_and_check();

        // Interlaced primary: 6 lines per field, 3 active, delay 3, pre line 5 (R2, R3, R9)
        sec = 1'b0; ilace = 1'b1; v_tot = 12'd12; v_act = 12'd6;
        restart();
        run_frames(192, 3, 6, 5, -1);
        stop_and_check();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule